// File: doc/BRIEF.md
# Thread Interrupt Context Register Rings

This block holds the interrupt-management state of one hardware thread. The state is split into four rings of 16 bytes each: user (ring 0), OS (ring 1), hypervisor pool (ring 2) and physical thread (ring 3). Each ring has three registers. The first is an 8-bit pending-buffer bitmap with one bit per priority. The second is a current-priority threshold. The third is a derived pending priority, which is the most favoured pending level. Priorities 0 to 7 are active, and 0 is the most favoured. The value 0xFF is the least favoured level.

Software reaches the rings through a byte-wide register port. A 2-bit page number selects one of four privilege views, and each view is narrower than the one before it: hardware, then hypervisor, then OS, then user. A separate update input lets the routing logic post new pending bits into any ring. The block raises an OS-level interrupt line for ring 1. It raises a hypervisor-level line for rings 2 and 3. A read of a ring's acknowledge register takes the most favoured pending interrupt and raises that ring's threshold to the priority just taken.

Top module: `thread_irq_ctx`

## Requirements
- R1: After reset every pending bitmap is 0, every threshold is 0x00, every pending priority reads 0xFF, and both interrupt lines are low.
- R2: When `upd_valid` is high, `upd_bits` is ORed into the pending bitmap of ring `upd_ring` at the next clock edge. The other rings keep their state.
- R3: A ring's pending priority equals the index of the lowest set bit of its pending bitmap. It is 0xFF when the bitmap is zero.
- R4: `os_irq` is high exactly when ring 1's pending priority is numerically below ring 1's threshold. `hv_irq` is the same test ORed over rings 2 and 3. Ring 0 drives neither line.
- R5: A threshold write with a value from 8 to 0xFE stores 0xFF. Values 0 to 7 and 0xFF are stored unchanged, and the interrupt lines follow the new value from the next cycle.
- R6: A read of the acknowledge register returns the pending priority. When that priority is not 0xFF, the read clears the matching pending bit and loads the threshold with it, so the ring's line is low in the next cycle. A read when nothing is pending returns 0xFF and changes nothing.
- R7: The byte address is ring*16 + register, with register 0 = pending bitmap, 1 = threshold, 2 = pending priority and 3 = acknowledge. Other register offsets read 0 and ignore writes, and writes to offsets 2 and 3 are ignored.
- R8: Page 0 (hardware) may write a pending bitmap directly. Page 1 (hypervisor) reaches all rings, but its writes to a pending bitmap are ignored.
- R9: Page 2 (OS) reaches rings 0 and 1 only. Its accesses to rings 2 and 3 read 0, ignore writes and acknowledge nothing.
- R10: Page 3 (user) reaches ring 0 only. Its accesses to rings 1, 2 and 3 read 0 and have no effect.
- R11: When an update and an acknowledge hit the same ring in the same cycle, the acknowledged bit is cleared first and the update bits are then ORed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_page | input | 2 | Privilege view: 0 hardware, 1 hypervisor, 2 OS, 3 user |
| acc_addr | input | 6 | Byte address: ring in bits 5:4, register in bits 3:0 |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid in the same cycle as a read access |
| upd_valid | input | 1 | Post pending bits this cycle |
| upd_ring | input | 2 | Ring that receives the update |
| upd_bits | input | 8 | Pending bits to OR in |
| hv_irq | output | 1 | Hypervisor-level interrupt line (rings 2 and 3) |
| os_irq | output | 1 | OS-level interrupt line (ring 1) |

## Verification
The assertions assume that every input carries a known value whenever reset is released. The stability checks for rejected accesses also assume that no update targets the same ring in that cycle, because an update may legitimately change the state there. The stimulus applies one access at a time and keeps updates apart from accesses. The only exception is one deliberate same-cycle update and acknowledge on ring 1, which the acknowledge assertion excludes by its antecedent.

// File: rtl/tctx_pkg.sv
package tctx_pkg;
    localparam int          N_RINGS   = 4;
    localparam int          RING_W    = $clog2(N_RINGS);
    localparam logic [7:0]  PRIO_NONE = 8'hFF;

    typedef enum logic [1:0] {
        RING_USER = 2'd0,
        RING_OS   = 2'd1,
        RING_POOL = 2'd2,
        RING_PHYS = 2'd3
    } ring_e;

    typedef enum logic [1:0] {
        PG_HW   = 2'd0,
        PG_HV   = 2'd1,
        PG_OS   = 2'd2,
        PG_USER = 2'd3
    } page_e;

    typedef enum logic [3:0] {
        REG_IPB  = 4'd0,
        REG_CPPR = 4'd1,
        REG_PIPR = 4'd2,
        REG_ACK  = 4'd3
    } reg_e;
endpackage

// File: rtl/tctx_prio_enc.sv
module tctx_prio_enc #(
    parameter int N_PRIO = 8
) (
    input  logic [N_PRIO-1:0] bits,
    output logic [7:0]        prio
);
    import tctx_pkg::*;

    // most favoured = lowest index; scan from the top so the lowest wins
    always_comb begin
        prio = PRIO_NONE;
        for (int i = N_PRIO - 1; i >= 0; i--) begin
            if (bits[i]) prio = 8'(i);
        end
    end
endmodule

// File: rtl/tctx_view_gate.sv
module tctx_view_gate (
    input  logic [1:0] page,
    input  logic [1:0] ring,
    output logic       ring_ok,
    output logic       ipb_wr_ok
);
    import tctx_pkg::*;

    always_comb begin
        unique case (page)
            PG_HW, PG_HV: ring_ok = 1'b1;
            PG_OS:        ring_ok = (ring <= RING_OS);
            PG_USER:      ring_ok = (ring == RING_USER);
            default:      ring_ok = 1'b0;
        endcase
        ipb_wr_ok = ring_ok && (page == PG_HW);
    end
endmodule

// File: rtl/thread_irq_ctx.sv
module thread_irq_ctx #(
    parameter int N_PRIO     = 8,
    parameter int RING_BYTES = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  acc_valid,
    input  logic                                  acc_write,
    input  logic [1:0]                            acc_page,
    input  logic [tctx_pkg::RING_W+$clog2(RING_BYTES)-1:0] acc_addr,
    input  logic [7:0]                            acc_wdata,
    output logic [7:0]                            acc_rdata,
    input  logic                                  upd_valid,
    input  logic [1:0]                            upd_ring,
    input  logic [N_PRIO-1:0]                     upd_bits,
    output logic                                  hv_irq,
    output logic                                  os_irq
);
    import tctx_pkg::*;

    localparam int REG_W  = $clog2(RING_BYTES);
    localparam int ADDR_W = RING_W + REG_W;
    localparam int PIDX_W = (N_PRIO > 1) ? $clog2(N_PRIO) : 1;

    typedef struct packed {
        logic [N_RINGS-1:0][N_PRIO-1:0] ipb;
        logic [N_RINGS-1:0][7:0]        cppr;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [N_RINGS-1:0][7:0] pipr;
    logic [N_RINGS-1:0]      irq_vec;
    logic [1:0]              ring_sel;
    logic [REG_W-1:0]        reg_sel;
    logic                    ring_ok, ipb_wr_ok;
    logic [7:0]              pipr_sel;
    logic [PIDX_W-1:0]       ack_idx;

    assign ring_sel = acc_addr[ADDR_W-1 -: RING_W];
    assign reg_sel  = acc_addr[REG_W-1:0];

    generate
        for (genvar r = 0; r < N_RINGS; r++) begin : g_ring
            tctx_prio_enc #(.N_PRIO(N_PRIO)) i_enc (
                .bits (ctx_q.ipb[r]),
                .prio (pipr[r])
            );
            assign irq_vec[r] = (pipr[r] < ctx_q.cppr[r]);
        end
    endgenerate

    tctx_view_gate i_gate (
        .page      (acc_page),
        .ring      (ring_sel),
        .ring_ok   (ring_ok),
        .ipb_wr_ok (ipb_wr_ok)
    );

    assign pipr_sel = pipr[ring_sel];
    assign ack_idx  = pipr_sel[PIDX_W-1:0];

    always_comb begin
        ctx_d     = ctx_q;
        acc_rdata = '0;
        if (acc_valid && ring_ok) begin
            unique case (reg_sel)
                REG_IPB: begin
                    if (!acc_write) acc_rdata = 8'(ctx_q.ipb[ring_sel]);
                    else if (ipb_wr_ok) ctx_d.ipb[ring_sel] = acc_wdata[N_PRIO-1:0];
                end
                REG_CPPR: begin
                    if (!acc_write) acc_rdata = ctx_q.cppr[ring_sel];
                    else ctx_d.cppr[ring_sel] =
                        (acc_wdata < 8'(N_PRIO)) ? acc_wdata : PRIO_NONE;
                end
                REG_PIPR: begin
                    if (!acc_write) acc_rdata = pipr_sel;
                end
                REG_ACK: begin
                    if (!acc_write) begin
                        acc_rdata = pipr_sel;
                        if (pipr_sel != PRIO_NONE) begin
                            ctx_d.ipb[ring_sel][ack_idx] = 1'b0;
                            ctx_d.cppr[ring_sel]         = pipr_sel;
                        end
                    end
                end
                default: acc_rdata = '0;
            endcase
        end
        // update lands after any acknowledge clear
        if (upd_valid) ctx_d.ipb[upd_ring] = ctx_d.ipb[upd_ring] | upd_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign os_irq = irq_vec[RING_OS];
    assign hv_irq = irq_vec[RING_POOL] | irq_vec[RING_PHYS];

    // ---------------- assertions ----------------
    generate
        for (genvar r = 0; r < N_RINGS; r++) begin : g_chk
            // R5: threshold is always an active level or 0xFF
            a_r5_cppr_legal: assert property (@(posedge clk) disable iff (!rst_n)
                (ctx_q.cppr[r] < 8'(N_PRIO)) || (ctx_q.cppr[r] == PRIO_NONE));
        end
    endgenerate

    // R2: posted bits are present one cycle later
    a_r2_update_sets: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ((ctx_q.ipb[$past(upd_ring)] & $past(upd_bits)) == $past(upd_bits)));

    // R4: hypervisor line needs a pending bit in pool or physical ring
    a_r4_hv_cause: assert property (@(posedge clk) disable iff (!rst_n)
        hv_irq |-> ((ctx_q.ipb[RING_POOL] | ctx_q.ipb[RING_PHYS]) != '0));

    // R6: acknowledging the OS ring drops the OS line
    a_r6_ack_drops_os: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && ring_ok && ring_sel == RING_OS &&
         reg_sel == REG_ACK && !upd_valid) |=> !os_irq);

    // R9: OS page cannot disturb pool or physical rings
    a_r9_os_page_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_page == PG_OS && ring_sel >= RING_POOL && !upd_valid)
        |=> ($stable(ctx_q.ipb[RING_POOL]) && $stable(ctx_q.ipb[RING_PHYS]) &&
             $stable(ctx_q.cppr[RING_POOL]) && $stable(ctx_q.cppr[RING_PHYS])));

    // R10: user page outside ring 0 leaves all state untouched
    a_r10_user_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_page == PG_USER && ring_sel != RING_USER && !upd_valid)
        |=> $stable(ctx_q));
endmodule

// File: tb/test_thread_irq_ctx.sv
module test_thread_irq_ctx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0] acc_page = '0;
    logic [5:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       upd_valid = 1'b0;
    logic [1:0] upd_ring = '0;
    logic [7:0] upd_bits = '0;
    logic       hv_irq, os_irq;

    int n_tests = 0, n_fail = 0;
    logic [7:0] rd;

    always #2 clk = ~clk; // 250 MHz

    thread_irq_ctx i_thread_irq_ctx (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_page(acc_page),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .upd_valid(upd_valid), .upd_ring(upd_ring), .upd_bits(upd_bits),
        .hv_irq(hv_irq), .os_irq(os_irq)
    );

    // pending bitmap written to ring 3, expected pending priority
    localparam logic [15:0] VEC [8] = '{
        16'h00FF, 16'h0100, 16'h8007, 16'h2803,
        16'hFE01, 16'h4006, 16'h2402, 16'h1004
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic access(input logic [1:0] pg, input logic wr, input logic [5:0] addr,
                          input logic [7:0] wd, output logic [7:0] rdv);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_page = pg; acc_addr = addr; acc_wdata = wd;
        #1 rdv = acc_rdata;
        @(posedge clk);
        #1 acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic post(input logic [1:0] ring, input logic [7:0] bits);
        @(negedge clk);
        upd_valid = 1'b1; upd_ring = ring; upd_bits = bits;
        @(posedge clk);
        #1 upd_valid = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        access(2'd0, 1'b0, 6'h10, 8'h00, rd); check("R1 ipb", rd, 8'h00);
        access(2'd0, 1'b0, 6'h11, 8'h00, rd); check("R1 cppr", rd, 8'h00);
        access(2'd0, 1'b0, 6'h32, 8'h00, rd); check("R1 pipr", rd, 8'hFF);
        check("R1 os_irq", {7'd0, os_irq}, 8'h00);
        check("R1 hv_irq", {7'd0, hv_irq}, 8'h00);

        // R3 / R7 vector walk on ring 3
        for (int i = 0; i < 8; i++) begin
            access(2'd0, 1'b1, 6'h30, VEC[i][15:8], rd);
            access(2'd0, 1'b0, 6'h30, 8'h00, rd); check("R7 ipb readback", rd, VEC[i][15:8]);
            access(2'd0, 1'b0, 6'h32, 8'h00, rd); check("R3 pipr", rd, VEC[i][7:0]);
        end
        access(2'd0, 1'b1, 6'h30, 8'h00, rd);

        // R10 / R4: user page owns ring 0, which drives no line
        access(2'd3, 1'b1, 6'h01, 8'hFF, rd);
        post(2'd0, 8'h01);
        access(2'd3, 1'b0, 6'h00, 8'h00, rd); check("R10 user ring0", rd, 8'h01);
        check("R4 ring0 no os", {7'd0, os_irq}, 8'h00);
        check("R4 ring0 no hv", {7'd0, hv_irq}, 8'h00);

        // R5 threshold clamp
        access(2'd2, 1'b1, 6'h11, 8'h09, rd);
        access(2'd0, 1'b0, 6'h11, 8'h00, rd); check("R5 clamp 09", rd, 8'hFF);
        access(2'd2, 1'b1, 6'h11, 8'h05, rd);
        access(2'd0, 1'b0, 6'h11, 8'h00, rd); check("R5 keep 05", rd, 8'h05);
        access(2'd2, 1'b1, 6'h11, 8'hFF, rd);

        // R2 / R4 OS line
        post(2'd1, 8'h08);
        check("R4 os raised", {7'd0, os_irq}, 8'h01);
        access(2'd0, 1'b0, 6'h20, 8'h00, rd); check("R2 ring2 untouched", rd, 8'h00);
        access(2'd2, 1'b1, 6'h11, 8'h03, rd);
        check("R4 equal prio masked", {7'd0, os_irq}, 8'h00);
        access(2'd2, 1'b1, 6'h11, 8'h04, rd);
        check("R5 rewrite reevaluates", {7'd0, os_irq}, 8'h01);

        // R6 acknowledge
        access(2'd2, 1'b0, 6'h13, 8'h00, rd); check("R6 ack value", rd, 8'h03);
        check("R6 os dropped", {7'd0, os_irq}, 8'h00);
        access(2'd0, 1'b0, 6'h10, 8'h00, rd); check("R6 bit cleared", rd, 8'h00);
        access(2'd0, 1'b0, 6'h11, 8'h00, rd); check("R6 cppr loaded", rd, 8'h03);
        access(2'd2, 1'b0, 6'h13, 8'h00, rd); check("R6 empty ack", rd, 8'hFF);
        access(2'd0, 1'b0, 6'h11, 8'h00, rd); check("R6 empty keeps cppr", rd, 8'h03);

        // R11 ack and update together
        post(2'd1, 8'h22);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_page = 2'd2; acc_addr = 6'h13;
        upd_valid = 1'b1; upd_ring = 2'd1; upd_bits = 8'h01;
        #1 rd = acc_rdata;
        @(posedge clk);
        #1 acc_valid = 1'b0; upd_valid = 1'b0;
        check("R11 ack value", rd, 8'h01);
        access(2'd0, 1'b0, 6'h10, 8'h00, rd); check("R11 merged ipb", rd, 8'h21);
        check("R11 os raised", {7'd0, os_irq}, 8'h01);

        // R4 hypervisor line via pool ring
        access(2'd1, 1'b1, 6'h21, 8'hFF, rd);
        post(2'd2, 8'h80);
        check("R4 hv raised", {7'd0, hv_irq}, 8'h01);

        // R8 page privileges and R7 unmapped offsets
        access(2'd1, 1'b1, 6'h30, 8'h04, rd);
        access(2'd0, 1'b0, 6'h30, 8'h00, rd); check("R8 hv ipb write ignored", rd, 8'h00);
        access(2'd0, 1'b1, 6'h32, 8'h00, rd);
        access(2'd0, 1'b0, 6'h32, 8'h00, rd); check("R7 pipr write ignored", rd, 8'hFF);
        access(2'd0, 1'b0, 6'h25, 8'h00, rd); check("R7 unmapped reads 0", rd, 8'h00);

        // R9 OS page blocked from pool ring
        access(2'd2, 1'b0, 6'h20, 8'h00, rd); check("R9 os read pool", rd, 8'h00);
        access(2'd2, 1'b1, 6'h21, 8'h00, rd);
        access(2'd0, 1'b0, 6'h21, 8'h00, rd); check("R9 os write ignored", rd, 8'hFF);
        access(2'd2, 1'b0, 6'h23, 8'h00, rd); check("R9 os ack reads 0", rd, 8'h00);
        check("R9 hv still high", {7'd0, hv_irq}, 8'h01);

        // R10 user page blocked from OS ring
        access(2'd3, 1'b0, 6'h10, 8'h00, rd); check("R10 user read ring1", rd, 8'h00);
        access(2'd3, 1'b1, 6'h11, 8'h00, rd);
        access(2'd0, 1'b0, 6'h11, 8'h00, rd); check("R10 user write ignored", rd, 8'h01);

        // R6 hypervisor acknowledge on pool ring
        access(2'd0, 1'b0, 6'h23, 8'h00, rd); check("R6 pool ack", rd, 8'h07);
        check("R6 hv dropped", {7'd0, hv_irq}, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule